// File: doc/BRIEF.md
# Status and Burst-Count Poller

This block owns every access to a peripheral's 32-bit status register and turns it into three operations for a host-side controller. The first is a qualifying poll. The block reads the register and splits the word into a flag byte and a 16-bit burst count. It accepts the result only when every flag named in a caller mask is set and the burst count lies between 1 and 63. Otherwise it backs off for a fixed interval and reads again, until an overall deadline passes. The other two operations are single status writes: one requests command-ready and is followed by the same settle delay, and the other issues go.

The register transfers themselves are carried out by an external transaction sequencer. This block presents one request at a time: a write strobe and a full 32-bit write word, held until the sequencer answers. The sequencer returns a done pulse, an error flag and the 32-bit read word. Byte 0 of the register is the least significant byte of the word.

Flag positions in byte 0: valid = bit 7, command-ready = bit 6, go = bit 5, data-available = bit 4, data-expected = bit 3. Time is counted in clock cycles: one millisecond is `TICKS_PER_MS` cycles. The retry interval is `RETRY_MS` (2 ms), the poll deadline is `TIMEOUT_MS` (2000 ms), and R denotes `RETRY_MS*TICKS_PER_MS`.

Top module: `status_poller`

## Requirements
- R1: Every status access moves the whole 32-bit register; a write carries its flag in byte 0 (bits 7:0) and zero in bits 31:8, and the request with its write data stays stable until the sequencer's done pulse.
- R2: After a good read, `status_o` takes bits 7:0 of the read word and `burst_o` takes bits 23:8, with bits 15:8 as the low byte; bits 31:24 are ignored.
- R3: A poll passes only when every bit set in the mask captured at start is also set in the status byte; a zero mask checks only the burst count.
- R4: A poll passes only when the burst count is in 1..63; a count of 0 or of 64 and above does not qualify.
- R5: After a non-qualifying or failed read, the next read request appears exactly R+1 cycles after the cycle of the previous done pulse, leaving R cycles with no request in between.
- R6: A read answered with an error is retried and does not alter `status_o` or `burst_o`.
- R7: A poll that never qualifies ends with `pass_o`=0 once `TIMEOUT_MS` has elapsed since the start, at the end of a retry interval, with `done_o` high for exactly one cycle.
- R8: A command-ready request writes 0x00000040, then waits R cycles; `done_o` rises R+1 cycles after the write's done pulse.
- R9: A go request writes 0x00000020, and `done_o` rises the cycle after the write's done pulse.
- R10: After reset the block is idle: no request, `done_o`, `pass_o`, `busy_o` low, `status_o` and `burst_o` zero.
- R11: For a write operation, `pass_o` reports the inverse of the sequencer's error flag; a successful poll reports `pass_o`=1 one cycle after the qualifying read's done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poll_start_i | input | 1 | Start a qualifying poll (highest priority) |
| poll_mask_i | input | 8 | Flags that must all be set for a poll to pass |
| ready_req_i | input | 1 | Start a command-ready write |
| go_req_i | input | 1 | Start a go write (lowest priority) |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result of the completed operation |
| status_o | output | 8 | Status byte of the last good read |
| burst_o | output | 16 | Burst count of the last good read |
| xact_req_o | output | 1 | Transaction request to the sequencer, held until done |
| xact_write_o | output | 1 | 1 = write, 0 = read |
| xact_wdata_o | output | 32 | Full status word to write |
| xact_done_i | input | 1 | Sequencer completion pulse |
| xact_err_i | input | 1 | Sequencer reports a failed transfer |
| xact_rdata_i | input | 32 | Status word read back |

## Verification
The bench aims at the edges of the burst window. It feeds counts of 0, 1, 63, 64 and 256, the last with only the high byte set. A design that swapped the byte order, read the wrong bytes or used an off-by-one comparison would pass a poll it should reject, or reject one it should pass. Error replies are mixed among the reads: a design that captured error data would show the wrong status and burst at the end of a failed poll. The bench also measures the idle gap before each retry, the settle delay after a command-ready write and the time to the deadline, so a miscounted interval or a premature timeout shows up as a wrong cycle count.

// File: rtl/stspoll_pkg.sv
package stspoll_pkg;
  localparam int FLAG_VALID  = 7;
  localparam int FLAG_CMDRDY = 6;
  localparam int FLAG_GO     = 5;
  localparam int FLAG_AVAIL  = 4;
  localparam int FLAG_EXPECT = 3;

  localparam int REG_BYTES = 4;
  localparam int REG_W     = REG_BYTES * 8;
  localparam int BURST_W   = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_XACT, ST_WAIT, ST_DONE} state_e;
  typedef enum logic [1:0] {OP_POLL, OP_READY, OP_GO} op_e;

  function automatic logic [REG_W-1:0] flag_word(input int bit_pos);
    logic [REG_W-1:0] w;
    w = '0;
    w[bit_pos] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/stspoll_decode.sv
module stspoll_decode
  import stspoll_pkg::*;
#(
  parameter int BURST_MAX = 63
) (
  input  logic [REG_W-1:0]   rdata_i,
  input  logic [7:0]         mask_i,
  output logic [7:0]         status_o,
  output logic [BURST_W-1:0] burst_o,
  output logic               qualify_o
);
  logic flags_ok, burst_ok;

  always_comb begin
    status_o  = rdata_i[7:0];
    // byte 1 is the low half of the count
    burst_o   = {rdata_i[23:16], rdata_i[15:8]};
    flags_ok  = (status_o & mask_i) == mask_i;
    burst_ok  = (burst_o != '0) && (burst_o <= BURST_W'(BURST_MAX));
    qualify_o = flags_ok && burst_ok;
  end
endmodule

// File: rtl/stspoll_timer.sv
module stspoll_timer #(
  parameter int RETRY_CYC   = 200000,
  parameter int TIMEOUT_CYC = 200000000,
  localparam int WAIT_W     = $clog2(RETRY_CYC + 1),
  localparam int ELAP_W     = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic wait_load_i,
  output logic wait_done_o,
  output logic expired_o
);
  logic [WAIT_W-1:0] wait_cnt;
  logic [ELAP_W-1:0] elap_cnt;

  assign wait_done_o = (wait_cnt == '0);
  assign expired_o   = (elap_cnt >= ELAP_W'(TIMEOUT_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_cnt <= '0;
    end else if (wait_load_i) begin
      wait_cnt <= WAIT_W'(RETRY_CYC - 1);
    end else if (wait_cnt != '0) begin
      wait_cnt <= wait_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elap_cnt <= '0;
    end else if (clr_i) begin
      elap_cnt <= '0;
    end else if (!expired_o) begin
      elap_cnt <= elap_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/stspoll_fsm.sv
module stspoll_fsm
  import stspoll_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               poll_start_i,
  input  logic [7:0]         poll_mask_i,
  input  logic               ready_req_i,
  input  logic               go_req_i,
  input  logic               xact_done_i,
  input  logic               xact_err_i,
  input  logic [7:0]         dec_status_i,
  input  logic [BURST_W-1:0] dec_burst_i,
  input  logic               dec_qualify_i,
  input  logic               wait_done_i,
  input  logic               expired_i,
  output logic [7:0]         mask_o,
  output logic               tmr_clr_o,
  output logic               wait_load_o,
  output op_e                op_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               pass_o,
  output logic [7:0]         status_o,
  output logic [BURST_W-1:0] burst_o,
  output logic               xact_req_o,
  output logic               xact_write_o,
  output logic [REG_W-1:0]   xact_wdata_o
);
  state_e             state_q;
  op_e                op_q;
  logic [7:0]         mask_q;
  logic               pass_q;
  logic [7:0]         status_q;
  logic [BURST_W-1:0] burst_q;
  logic               accept;

  assign accept      = (state_q == ST_IDLE) && (poll_start_i || ready_req_i || go_req_i);
  assign tmr_clr_o   = (state_q == ST_IDLE) && poll_start_i;
  assign wait_load_o = (state_q == ST_XACT) && xact_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_POLL;
      mask_q   <= '0;
      pass_q   <= 1'b0;
      status_q <= '0;
      burst_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            pass_q  <= 1'b0;
            state_q <= ST_XACT;
            if (poll_start_i) begin
              op_q   <= OP_POLL;
              mask_q <= poll_mask_i;
            end else if (ready_req_i) begin
              op_q <= OP_READY;
            end else begin
              op_q <= OP_GO;
            end
          end
        end
        ST_XACT: begin
          if (xact_done_i) begin
            unique case (op_q)
              OP_POLL: begin
                if (!xact_err_i) begin
                  status_q <= dec_status_i;
                  burst_q  <= dec_burst_i;
                end
                if (!xact_err_i && dec_qualify_i) begin
                  pass_q  <= 1'b1;
                  state_q <= ST_DONE;
                end else begin
                  state_q <= ST_WAIT;
                end
              end
              OP_READY: begin
                pass_q  <= !xact_err_i;
                state_q <= ST_WAIT;
              end
              default: begin
                pass_q  <= !xact_err_i;
                state_q <= ST_DONE;
              end
            endcase
          end
        end
        ST_WAIT: begin
          if (wait_done_i) begin
            if (op_q != OP_POLL) begin
              state_q <= ST_DONE;
            end else if (expired_i) begin
              pass_q  <= 1'b0;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_XACT;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (op_q)
      OP_READY: xact_wdata_o = flag_word(FLAG_CMDRDY);
      OP_GO:    xact_wdata_o = flag_word(FLAG_GO);
      default:  xact_wdata_o = '0;
    endcase
  end

  assign xact_req_o   = (state_q == ST_XACT);
  assign xact_write_o = (op_q != OP_POLL);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_DONE);
  assign pass_o       = pass_q;
  assign status_o     = status_q;
  assign burst_o      = burst_q;
  assign mask_o       = mask_q;
  assign op_o         = op_q;
endmodule

// File: rtl/status_poller.sv
module status_poller
  import stspoll_pkg::*;
#(
  parameter int TICKS_PER_MS = 100000,
  parameter int RETRY_MS     = 2,
  parameter int TIMEOUT_MS   = 2000,
  parameter int BURST_MAX    = 63,
  localparam int RETRY_CYC   = RETRY_MS * TICKS_PER_MS,
  localparam int TIMEOUT_CYC = TIMEOUT_MS * TICKS_PER_MS
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        poll_start_i,
  input  logic [7:0]  poll_mask_i,
  input  logic        ready_req_i,
  input  logic        go_req_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        pass_o,
  output logic [7:0]  status_o,
  output logic [15:0] burst_o,
  output logic        xact_req_o,
  output logic        xact_write_o,
  output logic [31:0] xact_wdata_o,
  input  logic        xact_done_i,
  input  logic        xact_err_i,
  input  logic [31:0] xact_rdata_i
);
  logic [7:0]         mask_w;
  logic [7:0]         dec_status;
  logic [BURST_W-1:0] dec_burst;
  logic               dec_qualify;
  logic               tmr_clr, wait_load, wait_done, expired_w;
  op_e                op_w;

  stspoll_decode #(.BURST_MAX(BURST_MAX)) u_decode (
    .rdata_i   (xact_rdata_i),
    .mask_i    (mask_w),
    .status_o  (dec_status),
    .burst_o   (dec_burst),
    .qualify_o (dec_qualify)
  );

  stspoll_timer #(.RETRY_CYC(RETRY_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (tmr_clr),
    .wait_load_i (wait_load),
    .wait_done_o (wait_done),
    .expired_o   (expired_w)
  );

  stspoll_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .poll_start_i  (poll_start_i),
    .poll_mask_i   (poll_mask_i),
    .ready_req_i   (ready_req_i),
    .go_req_i      (go_req_i),
    .xact_done_i   (xact_done_i),
    .xact_err_i    (xact_err_i),
    .dec_status_i  (dec_status),
    .dec_burst_i   (dec_burst),
    .dec_qualify_i (dec_qualify),
    .wait_done_i   (wait_done),
    .expired_i     (expired_w),
    .mask_o        (mask_w),
    .tmr_clr_o     (tmr_clr),
    .wait_load_o   (wait_load),
    .op_o          (op_w),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .pass_o        (pass_o),
    .status_o      (status_o),
    .burst_o       (burst_o),
    .xact_req_o    (xact_req_o),
    .xact_write_o  (xact_write_o),
    .xact_wdata_o  (xact_wdata_o)
  );
endmodule

// File: rtl/stspoll_chk.sv
module stspoll_chk
  import stspoll_pkg::*;
#(
  parameter int BURST_MAX = 63
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        pass_o,
  input logic [15:0] burst_o,
  input logic        xact_req_o,
  input logic        xact_write_o,
  input logic [31:0] xact_wdata_o,
  input logic        xact_done_i,
  input op_e         op_w,
  input logic        expired_w
);
  // R1
  wdata_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xact_req_o && xact_write_o) |-> (xact_wdata_o[31:8] == 24'h0));

  // R1
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xact_req_o && !xact_done_i) |=>
      (xact_req_o && $stable(xact_write_o) && $stable(xact_wdata_o)));

  // R4
  burst_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pass_o && op_w == OP_POLL) |->
      (burst_o != 16'h0 && burst_o <= 16'(BURST_MAX)));

  // R7
  timeout_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pass_o && op_w == OP_POLL) |-> expired_w);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  go_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xact_req_o && op_w == OP_GO) |-> (xact_write_o && xact_wdata_o == 32'h20));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!xact_req_o && !done_o));
endmodule

bind status_poller stspoll_chk #(.BURST_MAX(BURST_MAX)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .pass_o       (pass_o),
  .burst_o      (burst_o),
  .xact_req_o   (xact_req_o),
  .xact_write_o (xact_write_o),
  .xact_wdata_o (xact_wdata_o),
  .xact_done_i  (xact_done_i),
  .op_w         (op_w),
  .expired_w    (expired_w)
);

// File: tb/tb_status_poller.sv
module tb_status_poller;
  localparam int TPM    = 10;
  localparam int RMS    = 2;
  localparam int TMS    = 20;
  localparam int RCYC   = RMS * TPM;
  localparam int TCYC   = TMS * TPM;
  localparam int LAT    = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        poll_start = 1'b0, ready_req = 1'b0, go_req = 1'b0;
  logic [7:0]  poll_mask = '0;
  logic        busy, done, pass;
  logic [7:0]  status;
  logic [15:0] burst;
  logic        xreq, xwr;
  logic [31:0] xwdata;
  logic        xdone = 1'b0, xerr = 1'b0;
  logic [31:0] xrdata = '0;

  always #10 clk = ~clk;  // 50 MHz

  status_poller #(.TICKS_PER_MS(TPM), .RETRY_MS(RMS), .TIMEOUT_MS(TMS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .poll_start_i(poll_start), .poll_mask_i(poll_mask),
    .ready_req_i(ready_req), .go_req_i(go_req), .busy_o(busy), .done_o(done),
    .pass_o(pass), .status_o(status), .burst_o(burst), .xact_req_o(xreq),
    .xact_write_o(xwr), .xact_wdata_o(xwdata), .xact_done_i(xdone),
    .xact_err_i(xerr), .xact_rdata_i(xrdata)
  );

  typedef struct {
    string tag;
    bit    pass;
    bit    chk_data;
    int    status;
    int    burst;
    int    nreads;
    int    lat;      // cycles from last sequencer done to done_o, -1 skip
    int    gap;      // retry gap between reads, -1 skip
    int    dur_min;  // -1 skip
    int    dur_max;
    int    wdata;    // -1 skip
  } exp_t;

  typedef struct { bit err; logic [31:0] data; } resp_t;

  exp_t  exp_q[$];
  resp_t resp_q[$];
  int n_cmp = 0, n_bad = 0, n_done = 0;
  int cyc = 0;
  int start_cyc = 0, last_done_cyc = 0, nreads = 0;
  int gap_min = 0, gap_max = 0;
  int last_wdata = 0;
  bit wr_err = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, longint act, longint expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // sequencer model
  initial begin
    forever begin
      @(negedge clk);
      if (xreq) begin
        if (xwr) begin
          last_wdata = int'(xwdata);
        end else begin
          if (nreads > 0) begin
            if (nreads == 1 || cyc - last_done_cyc < gap_min) gap_min = cyc - last_done_cyc;
            if (nreads == 1 || cyc - last_done_cyc > gap_max) gap_max = cyc - last_done_cyc;
          end
          nreads++;
        end
        repeat (LAT - 1) @(negedge clk);
        if (xwr) begin
          xerr = wr_err; xrdata = '0;
        end else if (resp_q.size() > 0) begin
          resp_t r;
          r = resp_q.pop_front();
          xerr = r.err; xrdata = r.data;
        end else begin
          xerr = 1'b1; xrdata = 32'hFFFF_FFFF;
        end
        xdone = 1'b1;
        last_done_cyc = cyc;
        @(negedge clk);
        xdone = 1'b0; xerr = 1'b0; xrdata = '0;
      end
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          chk("R7 unexpected done", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk({e.tag, " pass"}, pass, e.pass);
          if (e.chk_data) begin
            chk({e.tag, " status"}, status, e.status);
            chk({e.tag, " burst"}, burst, e.burst);
            chk({e.tag, " reads"}, nreads, e.nreads);
          end
          if (e.lat >= 0) chk({e.tag, " latency"}, cyc - last_done_cyc, e.lat);
          if (e.gap >= 0) begin
            chk({e.tag, " gap min"}, gap_min, e.gap);
            chk({e.tag, " gap max"}, gap_max, e.gap);
          end
          if (e.dur_min >= 0)
            chk({e.tag, " deadline window"},
                ((cyc - start_cyc) >= e.dur_min && (cyc - start_cyc) <= e.dur_max), 1);
          if (e.wdata >= 0) chk({e.tag, " write word"}, last_wdata, e.wdata);
        end
        n_done++;
      end
    end
  end

  task automatic run(input int kind, input logic [7:0] mask, input exp_t e);
    int target;
    target = n_done + 1;
    exp_q.push_back(e);
    @(negedge clk);
    start_cyc = cyc; nreads = 0; gap_min = 0; gap_max = 0;
    poll_mask = mask;
    poll_start = (kind == 0); ready_req = (kind == 1); go_req = (kind == 2);
    @(negedge clk);
    poll_start = 1'b0; ready_req = 1'b0; go_req = 1'b0;
    while (n_done < target) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic exp_t mk(string tag, bit p, bit cd, int s, int b, int nr,
                              int lat, int gap, int dmin, int dmax, int wd);
    exp_t e;
    e.tag = tag; e.pass = p; e.chk_data = cd; e.status = s; e.burst = b;
    e.nreads = nr; e.lat = lat; e.gap = gap; e.dur_min = dmin; e.dur_max = dmax;
    e.wdata = wd;
    return e;
  endfunction

  function automatic resp_t rs(bit err, logic [31:0] d);
    resp_t r;
    r.err = err; r.data = d;
    return r;
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 req", xreq, 0);
    chk("R10 pass", pass, 0);
    chk("R10 status", status, 0);
    chk("R10 burst", burst, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 idle after release", {busy, xreq, done}, 0);

    // R2 R3 R11: byte 3 ignored, burst from bits 23:8
    resp_q.push_back(rs(0, 32'hAB_0005_90));
    run(0, 8'h90, mk("R2 R3 R11 simple poll", 1, 1, 'h90, 5, 1, 1, -1, -1, 0, -1));

    // R2 R4 R5: 0x0100 rejected (byte order), then 63 accepted
    resp_q.push_back(rs(0, 32'h0001_0090));
    resp_q.push_back(rs(0, 32'h0000_3F90));
    run(0, 8'h90, mk("R2 R4 R5 byte order", 1, 1, 'h90, 63, 2, 1, RCYC + 1, -1, 0, -1));

    // R3 R4 R5 R6: burst 0, flag missing, error, then burst 1
    resp_q.push_back(rs(0, 32'h0000_0090));
    resp_q.push_back(rs(0, 32'h0000_1080));
    resp_q.push_back(rs(1, 32'h0000_0598));
    resp_q.push_back(rs(0, 32'h0000_0198));
    run(0, 8'h90, mk("R3 R4 R5 R6 mixed", 1, 1, 'h98, 1, 4, 1, RCYC + 1, -1, 0, -1));

    // R3: zero mask, status zero
    resp_q.push_back(rs(0, 32'h0000_0200));
    run(0, 8'h00, mk("R3 zero mask", 1, 1, 0, 2, 1, 1, -1, -1, 0, -1));

    // R4 R6 R7: burst 64 then errors until deadline
    resp_q.push_back(rs(0, 32'h0000_40FF));
    run(0, 8'h80, mk("R4 R6 R7 timeout", 0, 0, 'hFF, 'h40, 0, RCYC + 1, -1,
                     TCYC, TCYC + RCYC + LAT + 4, -1));
    chk("R6 status after error replies", status, 'hFF);
    chk("R4 burst 64 kept but not passed", burst, 'h40);
    chk("R7 reads before deadline", (nreads >= 2 && nreads <= TCYC / RCYC + 1), 1);

    // R8 R1 R11 command-ready
    wr_err = 1'b0;
    run(1, 8'h00, mk("R8 R1 ready write", 1, 0, 0, 0, 0, RCYC + 1, -1, -1, 0, 'h40));
    chk("R8 status untouched", status, 'hFF);

    // R9 R1 go
    run(2, 8'h00, mk("R9 R1 go write", 1, 0, 0, 0, 0, 1, -1, -1, 0, 'h20));

    // R11 write error
    wr_err = 1'b1;
    run(2, 8'h00, mk("R11 go write error", 0, 0, 0, 0, 0, 1, -1, -1, 0, 'h20));
    run(1, 8'h00, mk("R11 ready write error", 0, 0, 0, 0, 0, RCYC + 1, -1, -1, 0, 'h40));
    wr_err = 1'b0;

    chk("R7 all results seen", exp_q.size(), 0);
    finish_run();
  end
endmodule